// File: doc/BRIEF.md
# Lockable Interrupt Request Controller

This block gathers a handful of interrupt request lines and presents one external-interrupt signal to a processor core. Software reaches it through a simple word-addressed register port. Each line has a mask bit, and a pending register records the lines that have fired. Software can write the pending register directly, set bits in it or clear bits in it. The port also holds a 64-bit handler address, two 64-bit debug scratch values and a cause index, which the core's software uses as shared storage.

A global lock word defers events. While the lock is nonzero, an enabled line event goes into a hidden deferred set and pending is left alone. Writing zero to the lock moves that set into pending and raises the output. The output is a state bit that specific events set and drop; it is not a function of pending. Direct pending writes and set writes leave it unchanged. A clear write drops it only when pending goes from nonzero to zero.

Top module: `irq_lock_ctrl`

## Requirements
- R1: After reset the mask reads all ones, the lock reads 1, pending and every other register read 0, the deferred set is empty, and `irq_o` is 0.
- R2: While the lock is 0, a rising event on line k with mask bit k equal to 0 sets pending bit k and makes `irq_o` 1 at the same clock edge. With mask bit k equal to 1 the event changes nothing.
- R3: While the lock is nonzero, a line event leaves pending unchanged and adds bit k to the deferred set only if mask bit k is 0. Writing 0 to the lock when pending or the deferred set is nonzero ORs the deferred set into pending, empties the set and sets `irq_o` to 1.
- R4: Writing exactly 1 to the lock while pending is nonzero sets `irq_o` to 0.
- R5: A write to the clear register removes the written 1-bits from pending. `irq_o` drops only if pending was nonzero before the write and is zero after it.
- R6: A write to the set register ORs the written value into pending. A write to the pending register replaces pending. Neither write changes `irq_o`.
- R7: Word offsets: 0 mask, 1 pending, 2 clear, 3 set, 4 and 5 handler address low and high, 6 and 7 debug cause low and high, 8 and 9 debug exception PC low and high, 10 lock, 11 cause index. Storage registers read back what was written, and the two 32-bit halves of each 64-bit value are written independently.
- R8: Reads of offsets 2 and 3 return 0. Reads of offsets 12 to 15 return all ones.
- R9: A write whose byte strobes are all zero has no effect. Any nonzero strobe pattern writes the full 32-bit word.
- R10: When a register write and a line event happen in the same cycle, the write is applied first. The event is then judged against the lock and mask values after the write.
- R11: Lines are edge-detected. A line that stays high produces one event only, at the first cycle it is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | NUM_LINES | Synchronous interrupt request lines |
| bus_valid_i | input | 1 | Register access valid |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | ADDR_W | Word offset |
| bus_strb_i | input | 4 | Byte strobes of the write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | External interrupt output to the core |

## Verification
The assertions assume that the request lines and the bus inputs change only between clock edges and that each register access lasts exactly one cycle. The clear-drop and unlock checks also assume that a line event in the same cycle cannot cancel what the write does. The bench drives every input on the falling edge and holds each write for one cycle. It combines line pulses with register writes only in the same-cycle ordering cases, and it computes the expected pending and output values there by hand. The mask and line sweeps cover all sixteen mask values in both the locked and the unlocked state.

// File: rtl/irq_lock_pkg.sv
package irq_lock_pkg;
    localparam int WORD_W = 32;
    localparam int STRB_W = WORD_W / 8;

    // Word offsets; software decodes these positions
    localparam int OFF_MASK   = 0;
    localparam int OFF_PEND   = 1;
    localparam int OFF_CLR    = 2;
    localparam int OFF_SET    = 3;
    localparam int OFF_HDL_LO = 4;
    localparam int OFF_HDL_HI = 5;
    localparam int OFF_DCS_LO = 6;
    localparam int OFF_DCS_HI = 7;
    localparam int OFF_DPC_LO = 8;
    localparam int OFF_DPC_HI = 9;
    localparam int OFF_LOCK   = 10;
    localparam int OFF_CIDX   = 11;

    typedef struct packed {
        logic [WORD_W-1:0]   mask;
        logic [WORD_W-1:0]   pending;
        logic [WORD_W-1:0]   lock;
        logic [WORD_W-1:0]   cause_idx;
        logic [2*WORD_W-1:0] handler;
        logic [2*WORD_W-1:0] dbg_cause;
        logic [2*WORD_W-1:0] dbg_pc;
    } sw_regs_t;
endpackage

// File: rtl/irq_lock_edge.sv
module irq_lock_edge #(
    parameter int NUM_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines_i,
    output logic [NUM_LINES-1:0] evt_o
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic prev_d, prev_q;

        always_comb begin
            prev_d = lines_i[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= prev_d;
        end

        assign evt_o[g] = lines_i[g] & ~prev_q;
    end
endmodule

// File: rtl/irq_lock_core.sv
module irq_lock_core
    import irq_lock_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic [NUM_LINES-1:0] evt_i,
    output sw_regs_t             regs_o,
    output logic                 irq_o
);
    localparam int HALF = WORD_W;

    typedef struct packed {
        sw_regs_t             regs;
        logic [NUM_LINES-1:0] defer;
        logic                 out;
    } state_t;

    state_t st_d, st_q;
    logic [WORD_W-1:0] defer_wide;

    always_comb begin
        defer_wide = '0;
        defer_wide[NUM_LINES-1:0] = st_q.defer;
    end

    always_comb begin
        st_d = st_q;
        // register write first
        if (wr_en) begin
            case (int'(wr_addr))
                OFF_MASK: st_d.regs.mask = wr_data;
                OFF_PEND: st_d.regs.pending = wr_data;
                OFF_CLR: begin
                    st_d.regs.pending = st_q.regs.pending & ~wr_data;
                    if (st_q.regs.pending != '0 && st_d.regs.pending == '0)
                        st_d.out = 1'b0;
                end
                OFF_SET:    st_d.regs.pending = st_q.regs.pending | wr_data;
                OFF_HDL_LO: st_d.regs.handler[HALF-1:0] = wr_data;
                OFF_HDL_HI: st_d.regs.handler[2*HALF-1:HALF] = wr_data;
                OFF_DCS_LO: st_d.regs.dbg_cause[HALF-1:0] = wr_data;
                OFF_DCS_HI: st_d.regs.dbg_cause[2*HALF-1:HALF] = wr_data;
                OFF_DPC_LO: st_d.regs.dbg_pc[HALF-1:0] = wr_data;
                OFF_DPC_HI: st_d.regs.dbg_pc[2*HALF-1:HALF] = wr_data;
                OFF_LOCK: begin
                    st_d.regs.lock = wr_data;
                    if (wr_data == '0 && (st_q.regs.pending != '0 || st_q.defer != '0)) begin
                        st_d.regs.pending = st_q.regs.pending | defer_wide;
                        st_d.defer = '0;
                        st_d.out = 1'b1;
                    end else if (wr_data == WORD_W'(1) && st_q.regs.pending != '0) begin
                        st_d.out = 1'b0;
                    end
                end
                OFF_CIDX: st_d.regs.cause_idx = wr_data;
                default: ;
            endcase
        end
        // line events afterwards, against post-write lock and mask
        for (int k = 0; k < NUM_LINES; k++) begin
            if (evt_i[k]) begin
                if (st_d.regs.lock != '0) begin
                    st_d.defer[k] = st_d.defer[k] | ~st_d.regs.mask[k];
                end else if (!st_d.regs.mask[k]) begin
                    st_d.regs.pending[k] = 1'b1;
                    st_d.out = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            st_q.regs.mask <= '1;
            st_q.regs.lock <= WORD_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.regs;
    assign irq_o  = st_q.out;

    // pending is frozen against line events while locked
    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.regs.lock != '0 && !wr_en) |=> $stable(st_q.regs.pending));

    // unlock with work outstanding raises the output
    p_unlock_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) == OFF_LOCK && wr_data == '0 &&
         (st_q.regs.pending != '0 || st_q.defer != '0)) |=> irq_o);

    // relocking with pending nonzero drops the output
    p_relock_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) == OFF_LOCK && wr_data == WORD_W'(1) &&
         st_q.regs.pending != '0) |=> !irq_o);

    // clearing the last pending bits drops the output when no line fires
    p_clear_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) == OFF_CLR && evt_i == '0 &&
         st_q.regs.pending != '0 && (st_q.regs.pending & ~wr_data) == '0) |=> !irq_o);

    // mask moves only on an accepted write
    p_mask_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.regs.mask));

    // output rises only after a line event or a write
    p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(evt_i != '0 || wr_en));
endmodule

// File: rtl/irq_lock_rdmux.sv
module irq_lock_rdmux
    import irq_lock_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  sw_regs_t          regs_i,
    output logic [WORD_W-1:0] data_o
);
    always_comb begin
        case (int'(addr_i))
            OFF_MASK:   data_o = regs_i.mask;
            OFF_PEND:   data_o = regs_i.pending;
            OFF_CLR:    data_o = '0;
            OFF_SET:    data_o = '0;
            OFF_HDL_LO: data_o = regs_i.handler[WORD_W-1:0];
            OFF_HDL_HI: data_o = regs_i.handler[2*WORD_W-1:WORD_W];
            OFF_DCS_LO: data_o = regs_i.dbg_cause[WORD_W-1:0];
            OFF_DCS_HI: data_o = regs_i.dbg_cause[2*WORD_W-1:WORD_W];
            OFF_DPC_LO: data_o = regs_i.dbg_pc[WORD_W-1:0];
            OFF_DPC_HI: data_o = regs_i.dbg_pc[2*WORD_W-1:WORD_W];
            OFF_LOCK:   data_o = regs_i.lock;
            OFF_CIDX:   data_o = regs_i.cause_idx;
            default:    data_o = '1;
        endcase
    end
endmodule

// File: rtl/irq_lock_ctrl.sv
module irq_lock_ctrl
    import irq_lock_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines_i,
    input  logic                 bus_valid_i,
    input  logic                 bus_write_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [STRB_W-1:0]    bus_strb_i,
    input  logic [WORD_W-1:0]    bus_wdata_i,
    output logic [WORD_W-1:0]    bus_rdata_o,
    output logic                 irq_o
);
    logic [NUM_LINES-1:0] evt;
    logic                 wr_en;
    sw_regs_t             regs;

    assign wr_en = bus_valid_i & bus_write_i & (|bus_strb_i);

    irq_lock_edge #(.NUM_LINES(NUM_LINES)) edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (irq_lines_i),
        .evt_o   (evt)
    );

    irq_lock_core #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (bus_addr_i),
        .wr_data (bus_wdata_i),
        .evt_i   (evt),
        .regs_o  (regs),
        .irq_o   (irq_o)
    );

    irq_lock_rdmux #(.ADDR_W(ADDR_W)) rdmux_i (
        .addr_i (bus_addr_i),
        .regs_i (regs),
        .data_o (bus_rdata_o)
    );
endmodule

// File: tb/irq_lock_ctrl_tb_top.sv
module irq_lock_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NL-1:0] lines = '0;
    logic        valid = 1'b0, write = 1'b0;
    logic [3:0]  addr = '0;
    logic [3:0]  strb = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_lock_ctrl #(.NUM_LINES(NL), .ADDR_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lines_i(lines),
        .bus_valid_i(valid), .bus_write_i(write), .bus_addr_i(addr),
        .bus_strb_i(strb), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lines = '0; valid = 1'b0; write = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_ev(input int a, input logic [31:0] d, input logic [3:0] s, input logic [NL-1:0] ln);
        @(negedge clk);
        valid = 1'b1; write = 1'b1; addr = 4'(a); wdata = d; strb = s; lines = ln;
        @(negedge clk);
        valid = 1'b0; write = 1'b0; strb = '0; lines = '0;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_ev(a, d, 4'hF, '0);
    endtask

    task automatic pulse(input logic [NL-1:0] ln);
        @(negedge clk);
        lines = ln;
        @(negedge clk);
        lines = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = 4'(a);
        #1 d = rdata;
    endtask

    initial begin
        logic [31:0] v;
        do_reset();

        // R1 reset state
        rd(0, v);  chk("R1 mask", v, 32'hFFFF_FFFF);
        rd(1, v);  chk("R1 pending", v, 0);
        rd(10, v); chk("R1 lock", v, 1);
        for (int a = 4; a < 10; a++) begin rd(a, v); chk("R1 scratch", v, 0); end
        rd(11, v); chk("R1 cause", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 unlocked sweep over all masks and lines
        for (int m = 0; m < 16; m++) begin
            for (int k = 0; k < NL; k++) begin
                do_reset();
                wr(0, 32'(m));
                wr(10, 0);
                pulse(NL'(1 << k));
                rd(1, v);
                chk("R2 pending", v, m[k] ? 32'd0 : 32'(1 << k));
                chk("R2 irq", {31'd0, irq}, m[k] ? 32'd0 : 32'd1);
            end
        end

        // R3 locked sweep: deferral then unlock
        for (int m = 0; m < 16; m++) begin
            do_reset();
            wr(0, 32'(m));
            for (int k = 0; k < NL; k++) pulse(NL'(1 << k));
            rd(1, v);
            chk("R3 locked pending", v, 0);
            chk("R3 locked irq", {31'd0, irq}, 0);
            wr(10, 0);
            rd(1, v);
            chk("R3 merged pending", v, 32'(~m & 15));
            chk("R3 unlock irq", {31'd0, irq}, ((~m & 15) != 0) ? 32'd1 : 32'd0);
        end

        // R4 relock drops output, unlock raises again
        do_reset();
        wr(0, 0); wr(10, 0); pulse(4'b0100);
        chk("R4 irq up", {31'd0, irq}, 1);
        wr(10, 1);
        chk("R4 relock irq", {31'd0, irq}, 0);
        rd(1, v); chk("R4 pending kept", v, 32'h4);
        wr(10, 0);
        chk("R4 unlock irq", {31'd0, irq}, 1);

        // R6 set ORs, R5 clear
        wr(3, 32'h30);
        rd(1, v); chk("R6 set", v, 32'h34);
        wr(2, 32'h04);
        rd(1, v); chk("R5 partial clear", v, 32'h30);
        chk("R5 irq stays", {31'd0, irq}, 1);
        wr(2, 32'h30);
        rd(1, v); chk("R5 full clear", v, 0);
        chk("R5 irq drop", {31'd0, irq}, 0);
        wr(3, 32'h1);
        chk("R6 set no raise", {31'd0, irq}, 0);
        wr(1, 32'h80);
        rd(1, v); chk("R6 replace", v, 32'h80);
        chk("R6 replace no raise", {31'd0, irq}, 0);

        // R7 storage readback, halves independent
        for (int a = 4; a < 10; a++) wr(a, 32'hA5000000 | 32'(a * 32'h111));
        wr(11, 32'hC0DE_0011);
        wr(0, 32'h0000_0F0F);
        for (int a = 4; a < 10; a++) begin
            rd(a, v); chk("R7 readback", v, 32'hA5000000 | 32'(a * 32'h111));
        end
        wr(5, 32'h1234_5678);
        rd(4, v); chk("R7 low half kept", v, 32'hA5000000 | 32'(4 * 32'h111));
        rd(5, v); chk("R7 high half", v, 32'h1234_5678);
        rd(11, v); chk("R7 cause idx", v, 32'hC0DE_0011);
        rd(0, v); chk("R7 mask", v, 32'h0000_0F0F);

        // R8 write-only and unmapped reads
        rd(2, v); chk("R8 clear reads 0", v, 0);
        rd(3, v); chk("R8 set reads 0", v, 0);
        for (int a = 12; a < 16; a++) begin rd(a, v); chk("R8 unmapped", v, 32'hFFFF_FFFF); end

        // R9 strobes
        wr_ev(0, 32'h1234_5678, 4'b0000, '0);
        rd(0, v); chk("R9 zero strobe ignored", v, 32'h0000_0F0F);
        wr_ev(0, 32'hDEAD_BEEF, 4'b0100, '0);
        rd(0, v); chk("R9 one lane full word", v, 32'hDEAD_BEEF);

        // R10 same-cycle ordering
        do_reset();
        wr(0, 0); wr(10, 0); pulse(4'b0001);
        wr_ev(2, 32'hF, 4'hF, 4'b0001);
        rd(1, v); chk("R10 clear then event", v, 32'h1);
        chk("R10 irq", {31'd0, irq}, 1);
        wr_ev(10, 1, 4'hF, 4'b1000);
        rd(1, v); chk("R10 lock then event deferred", v, 32'h1);
        chk("R10 relock irq", {31'd0, irq}, 0);
        wr(10, 0);
        rd(1, v); chk("R10 deferred merged", v, 32'h9);
        wr_ev(0, 32'hF, 4'hF, 4'b0010);
        rd(1, v); chk("R10 mask then event", v, 32'h9);

        // R11 level held high yields one event
        do_reset();
        wr(0, 0); wr(10, 0);
        @(negedge clk); lines = 4'b0010;
        @(negedge clk);
        rd(1, v); chk("R11 first event", v, 32'h2);
        @(negedge clk);
        valid = 1'b1; write = 1'b1; addr = 4'(2); wdata = 32'h2; strb = 4'hF;
        @(negedge clk);
        valid = 1'b0; write = 1'b0; strb = '0;
        repeat (3) @(negedge clk);
        rd(1, v); chk("R11 no repeat", v, 0);
        chk("R11 irq low", {31'd0, irq}, 0);
        lines = '0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule